// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the host-side sequencer for an external parallel bus in which sixteen pins carry both the address and the data. An internal client presents a request: an address, write data, a direction bit and a device-width bit. It raises a start strobe while the block is not busy. The block latches the request and runs a fixed sequence. First it drives the address with the latch-enable high. Then it asserts the active-low read or write strobe for a fixed number of clocks. Finally it releases the pins for a recovery gap, pulsing done on the first clock of that gap.

Two device widths are supported. For a 16-bit device the address is 16 bits wide and goes out whole during the latch phase; data uses all sixteen pins. For an 8-bit device the address is 24 bits wide. Its upper sixteen bits are latched, and its low byte rides on the upper pins during the strobe while the data byte uses the lower pins. Phase lengths are parameters, so every transfer in a given configuration takes the same number of clocks.

Top module: `pbus_master`

## Requirements
- R1: After reset, busy_o and done_o are 0, ale_o is 0, rd_no and wr_no are 1, ad_oe_o is 2'b00, ad_o is 0 and rdata_o is 0.
- R2: A start is taken only on a clock edge where busy_o is 0. A start raised while busy_o is 1 has no effect: no further latch phase follows, and busy_o stays 0 after the current transfer.
- R3: On acceptance, busy_o rises and ale_o is high for ALE_CYC clocks with ad_oe_o = 2'b11. ad_o carries addr[15:0] in 16-bit mode and addr[23:8] in 8-bit mode.
- R4: After ale_o falls, the strobe is low for STRB_CYC clocks: wr_no for a write, rd_no for a read. The two strobes are never low together, and neither is low while ale_o is high.
- R5: During a write strobe, ad_oe_o = 2'b11. ad_o is wdata[15:0] in 16-bit mode and {addr[7:0], wdata[7:0]} in 8-bit mode.
- R6: During a read strobe in 16-bit mode, ad_oe_o = 2'b00 and ad_o = 0. In 8-bit mode, ad_oe_o = 2'b10 and ad_o = {addr[7:0], 8'h00}. Bit 1 of ad_oe_o enables ad_o[15:8]; bit 0 enables ad_o[7:0].
- R7: A read returns the value ad_i had on the clock edge where rd_no rises. In 8-bit mode this value is zero-extended from ad_i[7:0]. rdata_o holds it from the done cycle until the next read completes.
- R8: done_o is high for exactly one clock, on the clock right after the strobe ends.
- R9: After the strobe, IDLE_CYC clocks follow with busy_o high, ale_o low, both strobes high and ad_oe_o = 2'b00. Then busy_o falls.
- R10: Direction, width, address and data are captured at acceptance. Changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Start request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mode8_i | input | 1 | 1 = 8-bit device, 0 = 16-bit device |
| req_addr_i | input | 24 | Transfer address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read result |
| ad_o | output | 16 | Multiplexed pin output value |
| ad_oe_o | output | 2 | Per-byte output enable for ad_o |
| ad_i | input | 16 | Multiplexed pin input value |
| ale_o | output | 1 | Address latch enable, active high |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The hardest cases to reach from the ports are a start raised in the middle of a transfer and request fields changed after acceptance. Both must leave the running transfer untouched and start nothing afterwards. The bench holds the start high with a different direction, width and address from the latch phase until just before busy drops. It then checks that every pin still follows the original request, and that the bus stays idle for a clock after the transfer. Read sampling is pinned down by driving a different value on ad_i in every strobe clock except the last.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ADDR_W = 24;
  localparam int PIN_W  = 16;
  localparam int BYTE_W = PIN_W / 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ALE,
    PH_STRB,
    PH_RECOV
  } phase_e;

  typedef struct packed {
    logic              write;
    logic              mode8;
    logic [ADDR_W-1:0] addr;
    logic [PIN_W-1:0]  wdata;
  } req_t;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int ALE_CYC  = 1,
  parameter int STRB_CYC = 3,
  parameter int IDLE_CYC = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  req_t   req_i,
  output phase_e phase_o,
  output req_t   req_o,
  output logic   last_o,
  output logic   busy_o,
  output logic   done_o
);
  localparam int MAX_AS = (ALE_CYC > STRB_CYC) ? ALE_CYC : STRB_CYC;
  localparam int MAXC   = (MAX_AS > IDLE_CYC) ? MAX_AS : IDLE_CYC;
  localparam int CNT_W  = $clog2(MAXC) + 1;

  phase_e     phase_q;
  req_t       req_q;
  logic [CNT_W-1:0] cnt_q;
  logic       done_q;
  logic       cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      req_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_ALE;
            cnt_q   <= CNT_W'(ALE_CYC - 1);
            req_q   <= req_i;
          end
        end
        PH_ALE: begin
          if (cnt_zero) begin
            phase_q <= PH_STRB;
            cnt_q   <= CNT_W'(STRB_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STRB: begin
          if (cnt_zero) begin
            phase_q <= PH_RECOV;
            cnt_q   <= CNT_W'(IDLE_CYC - 1);
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RECOV: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign req_o   = req_q;
  assign last_o  = (phase_q == PH_STRB) && cnt_zero;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/pbus_pinmux.sv
module pbus_pinmux
  import pbus_pkg::*;
(
  input  phase_e           phase_i,
  input  req_t             req_i,
  output logic [PIN_W-1:0] ad_o,
  output logic [1:0]       ad_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no
);
  always_comb begin
    ad_o    = '0;
    ad_oe_o = 2'b00;
    ale_o   = 1'b0;
    rd_no   = 1'b1;
    wr_no   = 1'b1;
    case (phase_i)
      PH_ALE: begin
        ale_o   = 1'b1;
        ad_oe_o = 2'b11;
        ad_o    = req_i.mode8 ? req_i.addr[ADDR_W-1:BYTE_W] : req_i.addr[PIN_W-1:0];
      end
      PH_STRB: begin
        if (req_i.write) begin
          wr_no   = 1'b0;
          ad_oe_o = 2'b11;
          ad_o    = req_i.mode8 ? {req_i.addr[BYTE_W-1:0], req_i.wdata[BYTE_W-1:0]}
                                : req_i.wdata;
        end else begin
          rd_no = 1'b0;
          // 8-bit device still sees the low address byte on the upper pins
          if (req_i.mode8) begin
            ad_oe_o = 2'b10;
            ad_o    = {req_i.addr[BYTE_W-1:0], {BYTE_W{1'b0}}};
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pbus_rcap.sv
module pbus_rcap
  import pbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             mode8_i,
  input  logic [PIN_W-1:0] ad_i,
  output logic [PIN_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= mode8_i ? {{BYTE_W{1'b0}}, ad_i[BYTE_W-1:0]} : ad_i;
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int ALE_CYC  = 1,
  parameter int STRB_CYC = 3,
  parameter int IDLE_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_start_i,
  input  logic              req_write_i,
  input  logic              req_mode8_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PIN_W-1:0]  req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PIN_W-1:0]  rdata_o,
  output logic [PIN_W-1:0]  ad_o,
  output logic [1:0]        ad_oe_o,
  input  logic [PIN_W-1:0]  ad_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no
);
  req_t   req_in, req_q;
  phase_e phase;
  logic   last;

  assign req_in = '{write: req_write_i, mode8: req_mode8_i,
                    addr: req_addr_i, wdata: req_wdata_i};

  pbus_seq #(
    .ALE_CYC (ALE_CYC),
    .STRB_CYC(STRB_CYC),
    .IDLE_CYC(IDLE_CYC)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(req_start_i),
    .req_i  (req_in),
    .phase_o(phase),
    .req_o  (req_q),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  pbus_pinmux u_pinmux (
    .phase_i(phase),
    .req_i  (req_q),
    .ad_o   (ad_o),
    .ad_oe_o(ad_oe_o),
    .ale_o  (ale_o),
    .rd_no  (rd_no),
    .wr_no  (wr_no)
  );

  pbus_rcap u_rcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (last && !req_q.write),
    .mode8_i(req_q.mode8),
    .ad_i   (ad_i),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] ad_oe_o,
  input logic       ale_o,
  input logic       rd_no,
  input logic       wr_no
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R4
  ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no));
  // R3
  ale_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o == 2'b11 && busy_o));
  // R6
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o[0]);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!rd_no || !wr_no));
  // R9
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !ale_o && ad_oe_o == 2'b00 && rd_no && wr_no));
endmodule

bind pbus_master pbus_master_chk u_chk (.*);

// File: tb/pbus_master_bench.sv
module pbus_master_bench;
  localparam int A = 1, S = 3, I = 1;
  localparam int TOT = A + S + I;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, wr_b = 1'b0, m8_b = 1'b0;
  logic [23:0] addr_b = '0;
  logic [15:0] wdata_b = '0, ad_in = '0;
  logic        busy, done, ale, rd_n, wr_n;
  logic [15:0] rdata, ad;
  logic [1:0]  oe;
  int n_chk = 0, n_fail = 0;
  logic [15:0] last_rd = '0;

  always #2.5 clk = ~clk;

  pbus_master #(.ALE_CYC(A), .STRB_CYC(S), .IDLE_CYC(I)) u_pbus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_write_i(wr_b),
    .req_mode8_i(m8_b), .req_addr_i(addr_b), .req_wdata_i(wdata_b),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .ad_o(ad), .ad_oe_o(oe),
    .ad_i(ad_in), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec(logic b, logic d, logic l, logic r, logic w,
                                      logic [1:0] o, logic [15:0] p);
    return {9'd0, b, d, l, r, w, o, p};
  endfunction

  function automatic logic [31:0] obs();
    return vec(busy, done, ale, rd_n, wr_n, oe, ad);
  endfunction

  // called at a negedge with busy low; returns at a negedge with busy low
  task automatic run_txn(input logic w, input logic m, input logic [23:0] a,
                         input logic [15:0] d, input logic [15:0] dev, input logic disturb);
    logic [31:0] e;
    start = 1'b1; wr_b = w; m8_b = m; addr_b = a; wdata_b = d;
    @(negedge clk);
    start = disturb;
    if (disturb) begin  // R2 R10: new fields and start while busy
      wr_b = ~w; m8_b = ~m; addr_b = ~a; wdata_b = ~d;
    end
    for (int k = 0; k <= TOT; k++) begin
      ad_in = (k == A + S - 1) ? dev : ((k >= A && k < A + S) ? ~dev : 16'h5a5a);
      if (k == TOT - 1) start = 1'b0;
      if (k < A) begin
        e = vec(1, 0, 1, 1, 1, 2'b11, m ? a[23:8] : a[15:0]);
        chk(disturb ? "R3 R10 latch" : "R3 latch", obs(), e);
      end else if (k < A + S) begin
        if (w) begin
          e = vec(1, 0, 0, 1, 0, 2'b11, m ? {a[7:0], d[7:0]} : d);
          chk("R4 R5 write strobe", obs(), e);
        end else begin
          e = vec(1, 0, 0, 0, 1, m ? 2'b10 : 2'b00, m ? {a[7:0], 8'h00} : 16'h0);
          chk("R4 R6 read strobe", obs(), e);
        end
      end else if (k < TOT) begin
        e = vec(1, k == A + S, 0, 1, 1, 2'b00, 16'h0);
        chk("R8 R9 recovery", obs(), e);
        if (k == A + S) begin
          if (!w) last_rd = m ? {8'h00, dev[7:0]} : dev;
          chk("R7 read data", {16'h0, rdata}, {16'h0, last_rd});
        end
      end else begin
        chk("R9 release", obs(), vec(0, 0, 0, 1, 1, 2'b00, 16'h0));
        chk("R7 hold", {16'h0, rdata}, {16'h0, last_rd});
      end
      if (k < TOT) @(negedge clk);
    end
    if (disturb) begin
      @(negedge clk);
      chk("R2 ignored start", obs(), vec(0, 0, 0, 1, 1, 2'b00, 16'h0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", obs(), vec(0, 0, 0, 1, 1, 2'b00, 16'h0));
    chk("R1 reset rdata", {16'h0, rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", obs(), vec(0, 0, 0, 1, 1, 2'b00, 16'h0));
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 6; i++)
          run_txn(w[0], m[0],
                  {8'(i * 37 + 1), 8'(i * 91 + 3), 8'(255 - i * 13)},
                  {8'(i * 17 + 5), 8'(200 - i * 29)},
                  {8'(i * 53 + 7), 8'(i * 71 + 9)},
                  i == 2);
    // back-to-back reads leave rdata at the newest value
    run_txn(1'b0, 1'b0, 24'hffffff, 16'h0, 16'hffff, 1'b0);
    run_txn(1'b0, 1'b1, 24'h000000, 16'h0, 16'h0000, 1'b0);
    summary();
  end
endmodule